// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block hands a shared external memory bus to an outside master. The master asks for the bus with an active-low request that may change at any time relative to the clock. The block first passes the request through a flop synchronizer and takes the bus away from the internal bus engine. It then waits for the engine's current transaction to finish and turns off every output driver of the bus. Only after a further delay does it give the master an active-low acknowledge.

When the master lets go of the request, the acknowledge is withdrawn first. The bus drivers come back a fixed number of cycles later, and only after that does the internal engine get the bus back. A configuration input can hold off any hold request for as long as it stays set. While it is set the internal engine keeps the bus.

The output enables are split into pin groups: chip selects, byte strobes, the 32-bit data lines, word address lines, the asynchronous read, output and write strobes, the synchronous-burst strobes, and the SDRAM command lines. All groups switch together.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `eng_grant` is 1, `hold_ack_n` is 1 and every bit of `bus_oe` is 1.
- R2: With the bus engine idle and `hold_disable` clear, a request that falls between edge N and edge N+1 turns every `bus_oe` bit to 0 at edge N+4 (two synchronizer stages, then one cycle in the drain state). No output changes before then except `eng_grant`.
- R3: While `hold_disable` is 1 and the bus is with the internal engine, a held request changes no output. When the bit is cleared after edge C, `eng_grant` falls at edge C+1 and the hold proceeds.
- R4: `eng_grant` stays 1 through edge N+2 and falls at edge N+3, the cycle after the synchronized request is first seen. It stays 0 until the bus has been re-driven.
- R5: While `xfer_busy` is 1, the bus stays driven. If `xfer_busy` falls after edge B, the outputs float at edge B+1.
- R6: `hold_ack_n` goes low only while all outputs are floated, exactly 2 cycles (ACK_DELAY) after they float.
- R7: A request released after edge R raises `hold_ack_n` at edge R+3. It raises `bus_oe` at edge R+4, which is 4 cycles after the release and never before the acknowledge is high. It returns `eng_grant` at edge R+5.
- R8: A request withdrawn after edge W while still draining returns `eng_grant` at edge W+3. The outputs are never floated and the acknowledge is never given.
- R9: All bits of `bus_oe` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_n | input | 1 | Asynchronous bus request from the external master, active low |
| hold_disable | input | 1 | Configuration bit; 1 defers any hold |
| xfer_busy | input | 1 | Internal bus engine has a transaction in progress |
| eng_grant | output | 1 | Internal engine may start new transactions |
| hold_ack_n | output | 1 | Bus handed to the external master, active low |
| bus_oe | output | 7 | Output enables of the bus pin groups, 1 = driven |

## Verification
The bench times the full hold and release sequence from the moment the request pin moves. A design with a missing or extra synchronizer stage, or with a drain delay of the wrong length, moves its outputs one cycle off and fails there.

A long busy period is held across the request. A design that floats the bus without waiting for the engine drops `bus_oe` too early.

The disable bit is held for thirty cycles under a live request. A design that ignores it would grant the bus at once, and one that latches the bit too late would grant a cycle late.

A request withdrawn mid-drain must return to idle without floating. A design that commits to the hold too early shows a floated bus or a low acknowledge. On release, a design that re-drives the bus before raising the acknowledge fails the ordering check.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_FLOAT   = 3'd2,
        ST_GRANTED = 3'd3,
        ST_RELEASE = 3'd4,
        ST_REDRIVE = 3'd5
    } bha_state_e;

    // Pin groups whose drivers are switched by the arbiter
    typedef enum int {
        GRP_CHIPSEL = 0,
        GRP_BYTEEN  = 1,
        GRP_DATA    = 2,
        GRP_ADDR    = 3,
        GRP_ASTROBE = 4,
        GRP_BURST   = 5,
        GRP_SDRAM   = 6,
        GRP_COUNT   = 7
    } bha_group_e;

    typedef struct packed {
        logic grant;   // internal engine may use the bus
        logic ack_n;   // acknowledge to external master
        logic drive;   // bus pins driven
    } bha_ctl_t;

    function automatic bha_ctl_t bha_decode(bha_state_e st);
        bha_ctl_t c;
        c.grant = (st == ST_IDLE);
        c.ack_n = (st != ST_GRANTED);
        c.drive = (st == ST_IDLE) || (st == ST_DRAIN) || (st == ST_REDRIVE);
        return c;
    endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic req
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_n};
    end

    assign req = ~chain[STAGES-1];

endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
    import bha_pkg::*;
#(
    parameter int DRAIN_MIN = 1,
    parameter int ACK_DELAY = 2,
    parameter int REL_DELAY = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     hold_disable,
    input  logic     xfer_busy,
    output bha_ctl_t ctl
);
    localparam int MAXC  = (DRAIN_MIN > ACK_DELAY)
                         ? ((DRAIN_MIN > REL_DELAY) ? DRAIN_MIN : REL_DELAY)
                         : ((ACK_DELAY > REL_DELAY) ? ACK_DELAY : REL_DELAY);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(MAXC);
    localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_MIN - 1);
    localparam logic [CNT_W-1:0] ACK_LAST   = CNT_W'(ACK_DELAY - 1);
    localparam logic [CNT_W-1:0] REL_LAST   = CNT_W'(REL_DELAY - 1);

    bha_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req && !hold_disable) nxt = ST_DRAIN;
            ST_DRAIN:   if (!req) nxt = ST_IDLE;
                        else if (!xfer_busy && cnt >= DRAIN_LAST) nxt = ST_FLOAT;
            ST_FLOAT:   if (cnt == ACK_LAST) nxt = ST_GRANTED;
            ST_GRANTED: if (!req) nxt = ST_RELEASE;
            ST_RELEASE: if (cnt == REL_LAST) nxt = ST_REDRIVE;
            ST_REDRIVE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)    cnt <= '0;
            else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    assign ctl = bha_decode(state);

    // R3
    disable_holds_off_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && hold_disable) |=> state == ST_IDLE);

    // R8
    withdraw_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && !req) |=> state == ST_IDLE);

    // R5
    drain_waits_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && xfer_busy) |=> state != ST_FLOAT);

    // R2
    float_from_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLOAT && $changed(state)) |-> $past(state) == ST_DRAIN);

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DRAIN_MIN   = 1,
    parameter int ACK_DELAY   = 2,
    parameter int REL_DELAY   = 1,
    parameter int NUM_GROUPS  = GRP_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold_req_n,
    input  logic                  hold_disable,
    input  logic                  xfer_busy,
    output logic                  eng_grant,
    output logic                  hold_ack_n,
    output logic [NUM_GROUPS-1:0] bus_oe
);
    logic     req_s;
    bha_ctl_t ctl;

    bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (hold_req_n),
        .req     (req_s)
    );

    bha_fsm #(
        .DRAIN_MIN (DRAIN_MIN),
        .ACK_DELAY (ACK_DELAY),
        .REL_DELAY (REL_DELAY)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req          (req_s),
        .hold_disable (hold_disable),
        .xfer_busy    (xfer_busy),
        .ctl          (ctl)
    );

    assign eng_grant  = ctl.grant;
    assign hold_ack_n = ctl.ack_n;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_oe
        assign bus_oe[g] = ctl.drive;
    end

    // R6
    ack_only_floated_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_ack_n |-> bus_oe == '0);

    // R7
    redrive_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe[0]) |-> hold_ack_n && $past(hold_ack_n));

    // R4
    no_shared_owner_chk: assert property (@(posedge clk) disable iff (rst)
        !(eng_grant && (!hold_ack_n || bus_oe != '1)));

    // R5
    float_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_oe[0]) |-> !$past(xfer_busy));

    // R9
    groups_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_oe == '0) || (bus_oe == '1));

endmodule

// File: tb/test_bus_hold_arbiter.sv
module test_bus_hold_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold_req_n = 1'b1;
    logic          hold_disable = 1'b0;
    logic          xfer_busy = 1'b0;
    logic          eng_grant, hold_ack_n;
    logic [NG-1:0] bus_oe;

    bus_hold_arbiter i_bus_hold_arbiter (
        .clk          (clk),
        .rst          (rst),
        .hold_req_n   (hold_req_n),
        .hold_disable (hold_disable),
        .xfer_busy    (xfer_busy),
        .eng_grant    (eng_grant),
        .hold_ack_n   (hold_ack_n),
        .bus_oe       (bus_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    // Scoreboard: expected {grant, ack_n, drive} per cycle
    int       q_cyc[$];
    bit [2:0] q_val[$];
    string    q_tag[$];

    task automatic expect_at(int c, bit g, bit a, bit o, string tag);
        q_cyc.push_back(c);
        q_val.push_back({g, a, o});
        q_tag.push_back(tag);
    endtask

    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            automatic int       c   = q_cyc.pop_front();
            automatic bit [2:0] e   = q_val.pop_front();
            automatic string    t   = q_tag.pop_front();
            automatic logic [2:0] act;
            automatic logic [NG-1:0] oe_exp = e[0] ? '1 : '0;
            act = {eng_grant, hold_ack_n, bus_oe[0]};
            checks++;
            if (c != cyc) begin
                fails++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)", t, c, cyc);
            end else if (act !== e || bus_oe !== oe_exp) begin
                fails++;
                $display("FAIL %s: cycle %0d grant/ack_n/oe actual %b/%b/%b expected %b/%b/%b",
                         t, cyc, eng_grant, hold_ack_n, bus_oe, e[2], e[1], oe_exp);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic run_all();
        int n;
        // R1 reset state
        step(3);
        expect_at(cyc + 1, 1, 1, 1, "R1");
        rst = 1'b0;
        expect_at(cyc + 2, 1, 1, 1, "R1");
        step(4);

        // Basic hold, idle engine: R2, R4, R6, R9
        n = cyc;
        hold_req_n = 1'b0;
        expect_at(n + 2, 1, 1, 1, "R4");
        expect_at(n + 3, 0, 1, 1, "R4");
        expect_at(n + 4, 0, 1, 0, "R2");
        expect_at(n + 5, 0, 1, 0, "R6");
        expect_at(n + 6, 0, 0, 0, "R6");
        expect_at(n + 9, 0, 0, 0, "R9");
        step(10);
        // Release: R7
        n = cyc;
        hold_req_n = 1'b1;
        expect_at(n + 2, 0, 0, 0, "R7");
        expect_at(n + 3, 0, 1, 0, "R7");
        expect_at(n + 4, 0, 1, 1, "R7");
        expect_at(n + 5, 1, 1, 1, "R7");
        step(8);

        // Busy engine drains first: R5
        n = cyc;
        xfer_busy  = 1'b1;
        hold_req_n = 1'b0;
        for (int k = 3; k <= 12; k++) expect_at(n + k, 0, 1, 1, "R5");
        step(12);
        n = cyc;
        xfer_busy = 1'b0;
        expect_at(n + 1, 0, 1, 0, "R5");
        expect_at(n + 2, 0, 1, 0, "R6");
        expect_at(n + 3, 0, 0, 0, "R6");
        step(6);
        n = cyc;
        hold_req_n = 1'b1;
        expect_at(n + 3, 0, 1, 0, "R7");
        expect_at(n + 5, 1, 1, 1, "R7");
        step(8);

        // Disable bit defers the hold: R3
        n = cyc;
        hold_disable = 1'b1;
        hold_req_n   = 1'b0;
        for (int k = 1; k <= 30; k++) expect_at(n + k, 1, 1, 1, "R3");
        step(30);
        n = cyc;
        hold_disable = 1'b0;
        expect_at(n + 1, 0, 1, 1, "R3");
        expect_at(n + 2, 0, 1, 0, "R3");
        expect_at(n + 4, 0, 0, 0, "R3");
        step(6);
        n = cyc;
        hold_req_n = 1'b1;
        expect_at(n + 5, 1, 1, 1, "R7");
        step(8);

        // Withdraw while draining: R8
        n = cyc;
        xfer_busy  = 1'b1;
        hold_req_n = 1'b0;
        expect_at(n + 3, 0, 1, 1, "R8");
        step(6);
        n = cyc;
        hold_req_n = 1'b1;
        expect_at(n + 1, 0, 1, 1, "R8");
        expect_at(n + 2, 0, 1, 1, "R8");
        for (int k = 3; k <= 8; k++) expect_at(n + k, 1, 1, 1, "R8");
        step(9);
        xfer_busy = 1'b0;
        step(2);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            end
        join_any
        disable fork;
        if (q_cyc.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q_cyc.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule